// File: doc/BRIEF.md
# Multimode Timer Counter Channel

This block is a single 16-bit up/down counter that other logic uses for timing and position work. One of four modes selects what advances the count. Timer mode counts system clocks divided by a programmable prescaler. Gated timer mode does the same, but only while a gate input is at its programmed active level, which gives pulse width or duty cycle measurement. Event mode counts selected edges on an event input. Quadrature mode decodes two encoder phases into a position count.

Software configures the channel and reads or loads the counter through a small register port. The count direction comes from either a control bit or an external direction pin. In quadrature mode the direction comes from the phase order instead. Both external inputs pass through a synchronizer. They are then sampled once per four-clock slot, so that slot sets the finest resolution. One-cycle pulses mark a wrap upward past the maximum value and a wrap downward past zero, for use by neighbouring logic.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0x0000, the control register reads 0x0000, and both wrap pulses are low.
- R2: Address 0 is control. Bits [1:0] are the mode (0 timer, 1 gated, 2 event, 3 quadrature), [4:2] the prescale select N, bit 5 direction from pin, bit 6 software down, bit 7 gate active high, [9:8] edge select (bit 8 rising, bit 9 falling) and bit 10 run. Bits above 10 read as zero. Address 1 reads the counter, and a write there loads it at once, taking priority over any count step in the same cycle.
- R3: In timer mode with run set, the counter changes by exactly one every 4·2^N clocks. Any window of M such periods holds exactly M steps.
- R4: With run clear, the counter does not change in any mode.
- R5: In gated mode the counter steps at the timer rate only while the event input equals the gate-active-high bit, and holds otherwise.
- R6: In event mode each qualifying edge of the event input steps the counter by one. Rising edges count when bit 8 is set and falling edges count when bit 9 is set. Edges must be held for at least 8 clocks.
- R7: Outside quadrature mode, the direction is down when bit 5 is clear and bit 6 is set, or when bit 5 is set and the direction pin is high. Otherwise it is up.
- R8: A step up from 0xFFFF gives 0x0000 and a one-cycle overflow pulse in the cycle the counter wraps.
- R9: A step down from 0x0000 gives 0xFFFF and a one-cycle underflow pulse in the cycle the counter wraps.
- R10: In quadrature mode, with phase A on the event input and phase B on the direction input, the sequence AB = 00→10→11→01→00 counts up by one per transition, and the reverse order counts down.
- R11: In quadrature mode, a sampled change of both phases at once leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 counter) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational from regAddr |
| evtIn | input | 1 | Event, gate or phase A input |
| dirIn | input | 1 | Direction or phase B input |
| ovfPulse | output | 1 | One-cycle pulse on upward wrap |
| unfPulse | output | 1 | One-cycle pulse on downward wrap |

## Verification
The hardest case to reach from the ports is quadrature decoding around a double-phase change. Such a change is only seen if both inputs move between two slot samples, and the slot phase is not visible at the pins. The bench therefore changes both phases in the same cycle and holds every level for three slots. This makes each change land in exactly one slot sample whatever the phase, and it also makes the forward and reverse sequences deterministic. Wrap pulses are checked by loading values next to the boundary and running an exact number of slot periods between two control writes. Both the final count and the pulse count are then known exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PRE_W  = 3;
  localparam int CTRL_W = 11;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_GATED = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_QUAD  = 2'd3
  } tmrMode_e;

  // Field order fixes the control register bit positions (MSB first).
  typedef struct packed {
    logic             run;       // bit 10
    logic [1:0]       edgeSel;   // bit 9 falling, bit 8 rising
    logic             gateHigh;  // bit 7
    logic             dirDown;   // bit 6
    logic             dirExt;    // bit 5
    logic [PRE_W-1:0] preSel;    // bits 4:2
    tmrMode_e         mode;      // bits 1:0
  } tmrCtrl_t;

  typedef struct packed {
    logic step;
    logic down;
    logic load;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SLOT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              evtIn,
  input  logic              dirIn,
  output tmrCtrl_t          ctrl,
  output tmrStrobe_t        strb
);

  localparam int PDIV_W = (1 << PRE_W) - 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'(1);

  // Control register
  tmrCtrl_t ctrlQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ctrlQ <= '0;
    else if (wrEn && addr == CTRL_ADDR) ctrlQ <= tmrCtrl_t'(wrData);
  end
  assign ctrl = ctrlQ;

  // Resolution slot: one strobe every 2^SLOT_W clocks
  logic [SLOT_W-1:0] phase;
  logic              slot;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + SLOT_W'(1);
  end
  assign slot = (phase == {SLOT_W{1'b1}});

  // Prescaler counts slots; tick every 2^N slots
  logic [PDIV_W-1:0] preCnt;
  logic [PDIV_W-1:0] preMask;
  logic              tick;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (slot) preCnt <= preCnt + PDIV_W'(1);
  end
  assign preMask = ~({PDIV_W{1'b1}} << ctrlQ.preSel);
  assign tick    = slot && ((preCnt & preMask) == preMask);

  // Input synchronizers, one per external pin
  logic [1:0] rawIn;
  logic [1:0] syncIn;
  assign rawIn = {dirIn, evtIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    tmr_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[g]),
      .q   (syncIn[g])
    );
  end

  // Per-slot samples used as the "previous" value for edge detection
  logic evtSmp, dirSmp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtSmp <= 1'b0;
      dirSmp <= 1'b0;
    end else if (slot) begin
      evtSmp <= syncIn[0];
      dirSmp <= syncIn[1];
    end
  end

  logic evtNew, dirNew;
  logic evtRise, evtFall;
  logic [1:0] quadChg;
  logic quadValid, quadDown;
  logic dirSel;
  logic rawStep, rawDown;

  assign evtNew    = syncIn[0];
  assign dirNew    = syncIn[1];
  assign evtRise   = evtNew & ~evtSmp;
  assign evtFall   = ~evtNew & evtSmp;
  assign quadChg   = {evtNew, dirNew} ^ {evtSmp, dirSmp};
  assign quadValid = (quadChg == 2'b01) || (quadChg == 2'b10);
  // A leading B counts up: new A differs from old B
  assign quadDown  = (evtNew == dirSmp);
  assign dirSel    = ctrlQ.dirExt ? dirNew : ctrlQ.dirDown;

  always_comb begin
    rawStep = 1'b0;
    rawDown = dirSel;
    unique case (ctrlQ.mode)
      MODE_TIMER: rawStep = tick;
      MODE_GATED: rawStep = tick && (evtNew == ctrlQ.gateHigh);
      MODE_EVENT: rawStep = slot && ((ctrlQ.edgeSel[0] && evtRise) ||
                                     (ctrlQ.edgeSel[1] && evtFall));
      MODE_QUAD: begin
        rawStep = slot && quadValid;
        rawDown = quadDown;
      end
      default: rawStep = 1'b0;
    endcase
  end

  assign strb.step = rawStep && ctrlQ.run;
  assign strb.down = rawDown;
  assign strb.load = wrEn && (addr == COUNT_ADDR);

  // R3
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> !strb.step);

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             ovfPulse,
  output logic             unfPulse
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
      if (strb.load) begin
        cnt <= loadVal;
      end else if (strb.step) begin
        if (strb.down) begin
          cnt      <= cnt - ONE;
          unfPulse <= (cnt == '0);
        end else begin
          cnt      <= cnt + ONE;
          ovfPulse <= (cnt == {CNT_W{1'b1}});
        end
      end
    end
  end

  // R8
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (cnt == '0));

  // R9
  unf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> (cnt == {CNT_W{1'b1}}));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfPulse && unfPulse));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (cnt == $past(loadVal)));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.load) |-> ((cnt == $past(cnt)) ||
                           (cnt == $past(cnt) + ONE) ||
                           (cnt == $past(cnt) - ONE)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 2,
  parameter int SLOT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              evtIn,
  input  logic              dirIn,
  output logic              ovfPulse,
  output logic              unfPulse
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] COUNT_ADDR = ADDR_W'(1);

  tmrCtrl_t         ctrl;
  tmrStrobe_t       strb;
  logic [CNT_W-1:0] cnt;

  tmr_ctrl #(
    .ADDR_W     (ADDR_W),
    .SLOT_W     (SLOT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (regWrEn),
    .addr  (regAddr),
    .wrData(regWrData[CTRL_W-1:0]),
    .evtIn (evtIn),
    .dirIn (dirIn),
    .ctrl  (ctrl),
    .strb  (strb)
  );

  tmr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadVal (regWrData),
    .cnt     (cnt),
    .ovfPulse(ovfPulse),
    .unfPulse(unfPulse)
  );

  always_comb begin
    if (regAddr == CTRL_ADDR)       regRdData = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
    else if (regAddr == COUNT_ADDR) regRdData = cnt;
    else                            regRdData = '0;
  end

endmodule

// File: tb/tmr_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        evtIn = 1'b0;
  logic        dirIn = 1'b0;
  logic        ovfPulse, unfPulse;

  int tests = 0;
  int fails = 0;
  int ovfSeen = 0;
  int unfSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_channel dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn),
    .dirIn(dirIn), .ovfPulse(ovfPulse), .unfPulse(unfPulse)
  );

  always @(negedge clk) begin
    if (ovfPulse) ovfSeen++;
    if (unfPulse) unfSeen++;
  end

  function automatic logic [15:0] mkCtrl(bit run, logic [1:0] edgeSel, bit gateHigh,
                                         bit dirDown, bit dirExt, logic [2:0] pre,
                                         logic [1:0] mode);
    return {5'b0, run, edgeSel, gateHigh, dirDown, dirExt, pre, mode};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(logic [1:0] a, logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 count", v, 16'h0000);
    chk("R1 pulses", {14'b0, ovfPulse, unfPulse}, 16'h0000);
  endtask

  task automatic testRegs();
    logic [15:0] v;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R2 ctrl upper bits zero", v, 16'h07FF);
    wr(2'd0, mkCtrl(0, 2'b01, 1, 0, 1, 3'd5, 2'd2));
    rd(2'd0, v); chk("R2 ctrl readback", v, 16'h01B6);
    wr(2'd1, 16'hA5C3);
    rd(2'd1, v); chk("R2 count load", v, 16'hA5C3);
    wr(2'd0, mkCtrl(1, 2'b00, 0, 0, 0, 3'd0, 2'd0));
    idle(5);
    wr(2'd1, 16'h1234);
    rd(2'd1, v); chk("R2 load while running", v, 16'h1234);
    wr(2'd0, 16'h0000);
  endtask

  task automatic timerWindow(string req, logic [2:0] pre, int periods, int expDelta);
    logic [15:0] a, b;
    wr(2'd0, mkCtrl(1, 2'b00, 0, 0, 0, pre, 2'd0));
    idle(3);
    rd(2'd1, a);
    idle((4 << pre) * periods);
    rd(2'd1, b);
    chk(req, b - a, 16'(expDelta));
    wr(2'd0, 16'h0000);
  endtask

  task automatic testTimer();
    timerWindow("R3 prescale 0", 3'd0, 10, 10);
    timerWindow("R3 prescale 2", 3'd2, 10, 10);
    timerWindow("R3 prescale 7", 3'd7, 2, 2);
  endtask

  task automatic testStopped();
    logic [15:0] a, b;
    wr(2'd0, mkCtrl(0, 2'b00, 0, 0, 0, 3'd0, 2'd0));
    rd(2'd1, a); idle(64); rd(2'd1, b);
    chk("R4 timer stopped", b, a);
    wr(2'd0, mkCtrl(0, 2'b11, 0, 0, 0, 3'd0, 2'd2));
    rd(2'd1, a);
    for (int i = 0; i < 3; i++) begin
      evtIn = 1'b1; idle(12); evtIn = 1'b0; idle(12);
    end
    rd(2'd1, b);
    chk("R4 event stopped", b, a);
    wr(2'd0, 16'h0000);
  endtask

  task automatic gatedCase(string req, bit gateHigh, bit level, int expDelta);
    logic [15:0] a, b;
    evtIn = level;
    wr(2'd0, mkCtrl(1, 2'b00, gateHigh, 0, 0, 3'd0, 2'd1));
    idle(12);
    rd(2'd1, a); idle(64); rd(2'd1, b);
    chk(req, b - a, 16'(expDelta));
    wr(2'd0, 16'h0000);
    evtIn = 1'b0;
  endtask

  task automatic testGated();
    gatedCase("R5 high gate open", 1, 1, 16);
    gatedCase("R5 high gate closed", 1, 0, 0);
    gatedCase("R5 low gate open", 0, 0, 16);
    gatedCase("R5 low gate closed", 0, 1, 0);
  endtask

  task automatic eventCase(string req, logic [1:0] edgeSel, int expDelta);
    logic [15:0] a, b;
    evtIn = 1'b0;
    wr(2'd0, mkCtrl(1, edgeSel, 0, 0, 0, 3'd0, 2'd2));
    idle(12);
    rd(2'd1, a);
    for (int i = 0; i < 5; i++) begin
      evtIn = 1'b1; idle(12); evtIn = 1'b0; idle(12);
    end
    rd(2'd1, b);
    chk(req, b - a, 16'(expDelta));
    wr(2'd0, 16'h0000);
  endtask

  task automatic testEvent();
    eventCase("R6 rising", 2'b01, 5);
    eventCase("R6 falling", 2'b10, 5);
    eventCase("R6 both", 2'b11, 10);
    eventCase("R6 none", 2'b00, 0);
  endtask

  task automatic testDirection();
    logic [15:0] a, b;
    wr(2'd0, mkCtrl(1, 2'b00, 0, 1, 0, 3'd0, 2'd0));
    idle(3); rd(2'd1, a); idle(40); rd(2'd1, b);
    chk("R7 software down", a - b, 16'd10);
    dirIn = 1'b1;
    wr(2'd0, mkCtrl(1, 2'b00, 0, 0, 1, 3'd0, 2'd0));
    idle(12); rd(2'd1, a); idle(40); rd(2'd1, b);
    chk("R7 pin down", a - b, 16'd10);
    dirIn = 1'b0;
    idle(12); rd(2'd1, a); idle(40); rd(2'd1, b);
    chk("R7 pin up", b - a, 16'd10);
    wr(2'd0, 16'h0000);
  endtask

  task automatic testWrap();
    logic [15:0] v;
    wr(2'd1, 16'hFFFE);
    ovfSeen = 0; unfSeen = 0;
    wr(2'd0, mkCtrl(1, 2'b00, 0, 0, 0, 3'd0, 2'd0));
    idle(39);
    wr(2'd0, 16'h0000);
    rd(2'd1, v); chk("R8 count after wrap", v, 16'h0008);
    chk("R8 overflow pulses", 16'(ovfSeen), 16'd1);
    chk("R8 no underflow", 16'(unfSeen), 16'd0);
    wr(2'd1, 16'h0001);
    ovfSeen = 0; unfSeen = 0;
    wr(2'd0, mkCtrl(1, 2'b00, 0, 1, 0, 3'd0, 2'd0));
    idle(39);
    wr(2'd0, 16'h0000);
    rd(2'd1, v); chk("R9 count after wrap", v, 16'hFFF7);
    chk("R9 underflow pulses", 16'(unfSeen), 16'd1);
    chk("R9 no overflow", 16'(ovfSeen), 16'd0);
  endtask

  task automatic setAB(bit a, bit b);
    evtIn = a; dirIn = b; idle(12);
  endtask

  task automatic testQuad();
    logic [15:0] base, v;
    setAB(0, 0);
    wr(2'd1, 16'h0100);
    wr(2'd0, mkCtrl(1, 2'b00, 0, 0, 0, 3'd0, 2'd3));
    idle(12);
    rd(2'd1, base); chk("R10 start", base, 16'h0100);
    setAB(1, 0); setAB(1, 1); setAB(0, 1); setAB(0, 0);
    rd(2'd1, v); chk("R10 forward", v, 16'h0104);
    setAB(1, 0);
    rd(2'd1, v); chk("R10 forward one", v, 16'h0105);
    setAB(0, 0); setAB(0, 1); setAB(1, 1); setAB(1, 0); setAB(0, 0);
    rd(2'd1, v); chk("R10 reverse", v, 16'h0100);
    setAB(1, 1);
    rd(2'd1, v); chk("R11 double change ignored", v, 16'h0100);
    setAB(0, 0);
    rd(2'd1, v); chk("R11 double change back ignored", v, 16'h0100);
    wr(2'd0, 16'h0000);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          tests++; fails++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("  [TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testRegs();
    testTimer();
    testStopped();
    testGated();
    testEvent();
    testDirection();
    testWrap();
    testQuad();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule